// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software with a watchdog that runs over a programmable nominal period. A prescaler divides the system clock into ticks, and a tick counter measures time from the start of the current period. In window mode each period has a closed first half and an open second half. A service pulse (kick) that lands in the open half starts a new period. A kick in the closed half is a failure. Running past the end of the period without a valid kick is also a failure. Each failure raises a one-cycle system reset request and records its cause.

A simpler timeout mode drops the closed half, so any kick before the end of the period is accepted. Software selects the period and the mode with a single write strobe. It reads the recorded cause from a status output and clears that cause with a read strobe.

Top module: `win_wdog`

## Requirements
- R1: After reset, `rst_req` is 0, `cause` is 2'b00, the mode is window and the period select is 3.
- R2: The period is P = BASE_TICKS << sel ticks, where sel is the 3-bit select. One tick is 2^PRE_LOG2 clocks. The closed half covers tick counts below P/2.
- R3: In window mode, a kick whose tick count is below P/2 makes `rst_req` high in the next cycle and sets `cause` to 2'b01.
- R4: In window mode, a kick at a tick count of P/2 or more, and not in the final cycle of the period, restarts the period with no reset request.
- R5: If no valid kick arrives, `rst_req` rises exactly P*2^PRE_LOG2 cycles after the period starts and `cause` becomes 2'b10. A kick in the final cycle of the period is treated as an overflow.
- R6: In timeout mode (`cfg_mode` = 0), any kick before the final cycle restarts the period, and only overflow requests a reset.
- R7: `rst_req` lasts one cycle. The next period starts at that edge with the same mode and select.
- R8: A `cfg_we` pulse loads `cfg_sel` and `cfg_mode` and restarts the period. In the same cycle it overrides a kick and an overflow, so neither raises a reset request.
- R9: `stat_rd` clears `cause` to 2'b00 in the next cycle. A reset event in the same cycle takes priority and sets its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the select and mode |
| cfg_sel | input | 3 | Period select |
| cfg_mode | input | 1 | 1 = window mode, 0 = timeout mode |
| kick | input | 1 | Single-cycle service pulse |
| stat_rd | input | 1 | Read strobe that clears the cause |
| rst_req | output | 1 | One-cycle system reset request |
| cause | output | 2 | Last reset cause: 00 none, 01 early, 10 overflow |

## Verification
`rst_req` and `cause` are registered. They therefore change one cycle after the cycle that decides them: the kick cycle for an early kick, and the final cycle of the period for an overflow. After a restart edge the overflow request appears exactly P*2^PRE_LOG2 cycles later. The bench counts cycles from each restart edge, drives every strobe on a falling edge, and samples on the falling edge that follows the deciding cycle. It also checks the cycle just before each due cycle, so a request that arrives one cycle early or one cycle late is caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_EARLY = 2'b01,
        CAUSE_OVF   = 2'b10
    } cause_e;

    localparam logic MODE_TIMEOUT = 1'b0;
    localparam logic MODE_WINDOW  = 1'b1;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PRE_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (PRE_LOG2 == 0) begin : g_direct
            // Every clock is a tick; restart has nothing to clear.
            logic unused_w;
            assign unused_w = clk ^ rst_n ^ restart;
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRE_LOG2-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = restart ? '0 : pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = &pre_q;
        end
    endgenerate
endmodule

// File: rtl/wdg_period_sel.sv
module wdg_period_sel #(
    parameter int SEL_W      = 3,
    parameter int BASE_TICKS = 4,
    parameter int CNT_W      = 10
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half
);
    localparam int NSEL = 2 ** SEL_W;

    logic [CNT_W-1:0] lut [NSEL];

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_lut
            assign lut[g] = CNT_W'(BASE_TICKS << g);
        end
    endgenerate

    assign period = lut[sel];
    assign half   = lut[sel] >> 1;
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
    parameter int PRE_LOG2   = 10,
    parameter int SEL_W      = 3,
    parameter int BASE_TICKS = 4,
    parameter int RST_SEL    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_mode,
    input  logic             kick,
    input  logic             stat_rd,
    output logic             rst_req,
    output logic [1:0]       cause
);
    import wdg_pkg::*;

    localparam int MAX_TICKS = BASE_TICKS << (2 ** SEL_W - 1);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             win;
        logic             rst_req;
        cause_e           cause;
    } wd_state_t;

    wd_state_t st_d, st_q;

    logic             tick;
    logic             restart;
    logic [CNT_W-1:0] period_ticks;
    logic [CNT_W-1:0] half_ticks;
    logic             kick_early;
    logic             overflow;

    // Aliases used by the bound checker.
    logic             win_q;
    logic [CNT_W-1:0] cnt_q;
    assign win_q = st_q.win;
    assign cnt_q = st_q.cnt;

    wdg_prescaler #(.PRE_LOG2(PRE_LOG2)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    wdg_period_sel #(
        .SEL_W      (SEL_W),
        .BASE_TICKS (BASE_TICKS),
        .CNT_W      (CNT_W)
    ) u_psel (
        .sel    (st_q.sel),
        .period (period_ticks),
        .half   (half_ticks)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        restart      = 1'b0;

        kick_early = kick && st_q.win && (st_q.cnt < half_ticks);
        overflow   = tick && (st_q.cnt == period_ticks - 1'b1);

        if (stat_rd) st_d.cause = CAUSE_NONE;

        if (cfg_we) begin
            st_d.sel = cfg_sel;
            st_d.win = cfg_mode;
            st_d.cnt = '0;
            restart  = 1'b1;
        end else if (overflow) begin
            st_d.cnt     = '0;
            st_d.rst_req = 1'b1;
            st_d.cause   = CAUSE_OVF;
            restart      = 1'b1;
        end else if (kick_early) begin
            st_d.cnt     = '0;
            st_d.rst_req = 1'b1;
            st_d.cause   = CAUSE_EARLY;
            restart      = 1'b1;
        end else if (kick) begin
            st_d.cnt = '0;
            restart  = 1'b1;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.sel     <= SEL_W'(RST_SEL);
            st_q.win     <= MODE_WINDOW;
            st_q.rst_req <= 1'b0;
            st_q.cause   <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.rst_req;
    assign cause   = st_q.cause;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kick,
    input logic             cfg_we,
    input logic             stat_rd,
    input logic             rst_req,
    input logic [1:0]       cause,
    input logic             win,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] half,
    input logic [CNT_W-1:0] period
);
    // R3: a closed-half kick in window mode yields an early-cause request
    p_early_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && win && !cfg_we && (cnt < half)) |=> (rst_req && cause == 2'b01));

    // R5: the tick count never reaches the period length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period);

    // R6: in timeout mode the only possible cause is overflow
    p_timeout_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !cfg_we) |=> (rst_req -> cause == 2'b10));

    // R8: a configuration write never produces a reset request
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !rst_req);

    // R9: a request always carries a cause, even when a read strobe coincides
    p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cause != 2'b00);

    // R9: without a read or an event the cause holds
    p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !$past(stat_rd)) |-> $stable(cause));
endmodule

bind win_wdog wdg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .cfg_we  (cfg_we),
    .stat_rd (stat_rd),
    .rst_req (rst_req),
    .cause   (cause),
    .win     (win_q),
    .cnt     (cnt_q),
    .half    (half_ticks),
    .period  (period_ticks)
);

// File: tb/test_win_wdog.sv
module test_win_wdog;
    // Bench setup: 2 clocks per tick, BASE_TICKS = 4.
    // sel s gives a period of (4 << s) ticks, that is (8 << s) cycles.
    localparam int PRE_LOG2 = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       cfg_mode = 1'b1;
    logic       kick = 1'b0;
    logic       stat_rd = 1'b0;
    logic       rst_req;
    logic [1:0] cause;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    win_wdog #(.PRE_LOG2(PRE_LOG2), .SEL_W(3), .BASE_TICKS(4), .RST_SEL(3)) i_win_wdog (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_mode(cfg_mode), .kick(kick), .stat_rd(stat_rd),
        .rst_req(rst_req), .cause(cause)
    );

    // Vector fields: [16] mode, [15:13] sel, [12:3] kick cycle after restart,
    // [2] expected rst_req, [1:0] expected cause
    localparam logic [16:0] VECS [14] = '{
        {1'b1, 3'd0, 10'd3,   1'b1, 2'b01},
        {1'b1, 3'd0, 10'd4,   1'b0, 2'b00},
        {1'b1, 3'd0, 10'd6,   1'b0, 2'b00},
        {1'b1, 3'd0, 10'd7,   1'b1, 2'b10},
        {1'b0, 3'd0, 10'd0,   1'b0, 2'b00},
        {1'b0, 3'd0, 10'd3,   1'b0, 2'b00},
        {1'b0, 3'd0, 10'd7,   1'b1, 2'b10},
        {1'b1, 3'd1, 10'd7,   1'b1, 2'b01},
        {1'b1, 3'd1, 10'd8,   1'b0, 2'b00},
        {1'b1, 3'd1, 10'd15,  1'b1, 2'b10},
        {1'b1, 3'd2, 10'd15,  1'b1, 2'b01},
        {1'b1, 3'd2, 10'd16,  1'b0, 2'b00},
        {1'b1, 3'd7, 10'd511, 1'b1, 2'b01},
        {1'b1, 3'd7, 10'd512, 1'b0, 2'b00}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Writes mode/select; returns on the falling edge of cycle 0 of the new period
    task automatic cfg_write(input logic mode, input logic [2:0] sel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_mode = mode;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_cause();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // Kick in the current cycle; returns one cycle later, where results are due
    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rst_req after reset", {1'b0, rst_req}, 2'b00);
        check("R1 cause after reset", cause, 2'b00);
        // Default mode is window: a kick right after reset is early
        @(negedge clk);
        pulse_kick();
        check("R1 default window mode, rst_req", {1'b0, rst_req}, 2'b01);
        check("R1 default window mode, cause", cause, 2'b01);
        clear_cause();
        check("R9 read clears cause", cause, 2'b00);

        // Table walk (R2 period scaling with sel)
        foreach (VECS[i]) begin
            automatic logic       v_mode  = VECS[i][16];
            automatic logic [2:0] v_sel   = VECS[i][15:13];
            automatic int         v_k     = int'(VECS[i][12:3]);
            automatic logic       v_rst   = VECS[i][2];
            automatic logic [1:0] v_cause = VECS[i][1:0];
            automatic string      tag;
            tag = v_rst ? ((v_cause == 2'b01) ? "R3" : "R5")
                        : (v_mode ? "R4" : "R6");
            if (v_sel != 3'd0) tag = {tag, "/R2"};
            clear_cause();
            cfg_write(v_mode, v_sel);
            repeat (v_k) @(negedge clk);
            pulse_kick();
            check({tag, " vector rst_req"}, {1'b0, rst_req}, {1'b0, v_rst});
            check({tag, " vector cause"}, cause, v_cause);
        end

        // R4/R7: a valid kick restarts; the overflow then repeats every period
        clear_cause();
        cfg_write(1'b1, 3'd0);
        repeat (5) @(negedge clk);
        pulse_kick();
        check("R4 valid kick, no request", {1'b0, rst_req}, 2'b00);
        repeat (7) @(negedge clk);
        check("R4 restarted period, no request in cycle 7", {1'b0, rst_req}, 2'b00);
        @(negedge clk);
        check("R5 overflow after restart, rst_req", {1'b0, rst_req}, 2'b01);
        check("R5 overflow cause", cause, 2'b10);
        @(negedge clk);
        check("R7 request lasts one cycle", {1'b0, rst_req}, 2'b00);
        repeat (6) @(negedge clk);
        check("R7 next period, no request in cycle 7", {1'b0, rst_req}, 2'b00);
        @(negedge clk);
        check("R7 same period after request", {1'b0, rst_req}, 2'b01);

        // R8: a write overrides an early kick in the same cycle and restarts
        clear_cause();
        cfg_write(1'b1, 3'd0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_mode = 1'b1;
        pulse_kick();
        cfg_we = 1'b0;
        check("R8 write beats early kick, rst_req", {1'b0, rst_req}, 2'b00);
        check("R8 write beats early kick, cause", cause, 2'b00);
        repeat (7) @(negedge clk);
        check("R8 write restarted period, cycle 7", {1'b0, rst_req}, 2'b00);
        @(negedge clk);
        check("R8 overflow from write edge", {1'b0, rst_req}, 2'b01);

        // R8: a write in the final cycle suppresses the overflow
        clear_cause();
        cfg_write(1'b1, 3'd0);
        repeat (7) @(negedge clk);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8 write beats overflow, rst_req", {1'b0, rst_req}, 2'b00);
        check("R8 write beats overflow, cause", cause, 2'b00);

        // R9: an overflow in the same cycle as a read sets the cause anyway
        cfg_write(1'b1, 3'd0);
        repeat (7) @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 event beats read, rst_req", {1'b0, rst_req}, 2'b01);
        check("R9 event beats read, cause", cause, 2'b10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule